// File: doc/BRIEF.md
# Descriptor Assembly and Commit Port

This block is the write side of a DMA descriptor queue. Software builds one descriptor through a write-only memory-mapped port, using as many partial writes as it likes and touching the byte lanes in any order. Each write goes into a staging register, and only the lanes that are enabled change.

A descriptor enters the queue as a whole only when an accepted write sets the commit flag. The commit flag is the most significant bit of the descriptor, and that write must also enable the most significant byte lane. The committed descriptor is the staging content merged with the data of that same write. The staging register keeps its content after a commit, so the next descriptor can reuse fields that do not change.

A small FIFO holds the committed descriptors. A consumer drains it through a valid/ready pair. When the FIFO is full, the port stalls writers with a wait request, and a full flag tells an upstream fetch engine that there is no room for another descriptor.

Top module: `desc_commit_port`

## Requirements
- R1: After reset, `out_valid`, `wait_req` and `buf_full` are all low.
- R2: An accepted write updates only the staging byte lanes whose `wr_be` bit is set. Byte lane i covers data bits 8i+7..8i, and the lanes may be written in any order over several writes.
- R3: A write is a commit when it is accepted, `wr_be[BEW-1]` is set and `wr_data[DW-1]` is 1. A commit pushes the staging content merged with that write. The descriptor appears on `out_desc` with `out_valid` high from the next cycle.
- R4: A write is not a commit if it leaves the top lane disabled or has `wr_data[DW-1]` at 0. Such a write pushes nothing and only updates the staging lanes.
- R5: Committing does not clear the staging register. A later commit that writes only the top lane pushes the earlier lanes again.
- R6: `wait_req` and `buf_full` are high exactly when the FIFO holds FIFO_DEPTH descriptors. A pop in the same cycle does not lower them.
- R7: A write presented while `wait_req` is high has no effect. It does not change the staging register and it pushes nothing.
- R8: Descriptors leave in commit order. A pop happens when `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | BEW | Byte-lane enables |
| wr_data | input | DW | Write data; bit DW-1 is the commit flag |
| wait_req | output | 1 | Write held off |
| buf_full | output | 1 | Descriptor FIFO full |
| out_valid | output | 1 | A descriptor is available |
| out_ready | input | 1 | Consumer takes the head descriptor |
| out_desc | output | DW | Head descriptor |

## Verification
The bench builds the standard 128-bit port (EXTENDED=0) with FIFO_DEPTH=4. The shallow FIFO lets a few commits reach the full state, so the stall, the ignored write during a stall and the pop-while-full cycle can all be exercised. The narrow width keeps the 16-lane merge easy to follow in the reference model. A random phase with irregular `out_ready` then mixes partial writes, commits and pops against that model.

// File: rtl/desc_pkg.sv
package desc_pkg;

    localparam int STD_WIDTH = 128;
    localparam int EXT_WIDTH = 256;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_state_t;

    function automatic int desc_width(input bit extended);
        return extended ? EXT_WIDTH : STD_WIDTH;
    endfunction

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/desc_stage.sv
module desc_stage #(
    parameter int DW = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     data,
    output logic [DW-1:0]     merged,
    output logic              commit
);
    localparam int BEW = DW / 8;

    logic [DW-1:0] stage_q;

    for (genvar i = 0; i < BEW; i++) begin : g_lane
        assign merged[i*8 +: 8] = be[i] ? data[i*8 +: 8] : stage_q[i*8 +: 8];

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i*8 +: 8] <= '0;
            end else if (wr_ok && be[i]) begin
                stage_q[i*8 +: 8] <= data[i*8 +: 8];
            end
        end

        // R2: a disabled lane keeps its value
        a_r2_lane_hold: assert property (@(posedge clk) disable iff (rst)
            (wr_ok && !be[i]) |=> $stable(stage_q[i*8 +: 8]));
    end

    assign commit = wr_ok && be[BEW-1] && data[DW-1];

    // R7: no accepted write, no change to the staging register
    a_r7_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(stage_q));

endmodule

// File: rtl/desc_fifo.sv
module desc_fifo
    import desc_pkg::*;
#(
    parameter int DW    = 128,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop_rdy,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output fifo_state_t   state
);
    localparam int AW = ptr_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          pop;

    assign state.full  = (cnt == CW'(DEPTH));
    assign state.empty = (cnt == '0);
    assign out_valid   = !state.empty;
    assign out_data    = mem[rptr];
    assign pop         = pop_rdy && !state.empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R6: the writer never pushes into a full FIFO
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !state.full);

    // R3: a push is visible on the next cycle
    a_r3_valid_after_push: assert property (@(posedge clk) disable iff (rst)
        push |=> out_valid);

    // R6: occupancy stays within the depth
    always_comb begin
        if (!rst) a_r6_count_bound: assert (cnt <= CW'(DEPTH));
    end

endmodule

// File: rtl/desc_commit_port.sv
module desc_commit_port
    import desc_pkg::*;
#(
    parameter bit EXTENDED   = 1'b0,
    parameter int FIFO_DEPTH = 4,
    localparam int DW  = desc_width(EXTENDED),
    localparam int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [BEW-1:0] wr_be,
    input  logic [DW-1:0]  wr_data,
    output logic           wait_req,
    output logic           buf_full,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_desc
);
    fifo_state_t   fstate;
    logic          wr_ok;
    logic          commit;
    logic [DW-1:0] merged;

    assign wait_req = fstate.full;
    assign buf_full = fstate.full;
    assign wr_ok    = wr_en && !fstate.full;

    desc_stage #(.DW(DW)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .wr_ok  (wr_ok),
        .be     (wr_be),
        .data   (wr_data),
        .merged (merged),
        .commit (commit)
    );

    desc_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (commit),
        .push_data (merged),
        .pop_rdy   (out_ready),
        .out_valid (out_valid),
        .out_data  (out_desc),
        .state     (fstate)
    );

    // R7: a held-off write pushes nothing
    a_r7_no_commit_stalled: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wait_req) |-> !commit);

endmodule

// File: tb/test_desc_commit_port.sv
module test_desc_commit_port;
    localparam int DW = 128;
    localparam int BEW = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [BEW-1:0] wr_be = '0;
    logic [DW-1:0] wr_data = '0;
    logic out_ready = 1'b0;
    logic wait_req, buf_full, out_valid;
    logic [DW-1:0] out_desc;

    always #2.5 clk = ~clk;

    desc_commit_port #(.EXTENDED(1'b0), .FIFO_DEPTH(DEPTH)) i_desc_commit_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .wait_req(wait_req), .buf_full(buf_full), .out_valid(out_valid),
        .out_ready(out_ready), .out_desc(out_desc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";
    logic [DW-1:0] m_stage;
    logic [DW-1:0] m_q [$];

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic full_e;
        full_e = (m_q.size() == DEPTH);
        chk("wait_req", DW'(wait_req), DW'(full_e));
        chk("buf_full", DW'(buf_full), DW'(full_e));
        chk("out_valid", DW'(out_valid), DW'(m_q.size() > 0));
        if (m_q.size() > 0) chk("out_desc", out_desc, m_q[0]);
    endtask

    task automatic model_step();
        logic [DW-1:0] mg;
        bit full_now;
        full_now = (m_q.size() == DEPTH);
        if (out_ready && m_q.size() > 0) void'(m_q.pop_front());
        if (wr_en && !full_now) begin
            mg = m_stage;
            for (int i = 0; i < BEW; i++)
                if (wr_be[i]) mg[i*8 +: 8] = wr_data[i*8 +: 8];
            m_stage = mg;
            if (wr_be[BEW-1] && wr_data[DW-1]) m_q.push_back(mg);
        end
    endtask

    task automatic cyc(input logic w, input logic [BEW-1:0] be,
                       input logic [DW-1:0] d, input logic rdy);
        @(negedge clk);
        compare();
        wr_en = w; wr_be = be; wr_data = d; out_ready = rdy;
        @(posedge clk);
        model_step();
    endtask

    localparam logic [DW-1:0] CMT = {1'b1, 127'b0};

    initial begin
        m_stage = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        compare();
        // R2: lanes out of order, partial writes
        cur_req = "R2";
        cyc(1, 16'h00F0, {32'h0, 32'h0, 32'hAAAA_BBBB, 32'h0}, 0);
        cyc(1, 16'h000F, {96'h0, 32'h1111_2222}, 0);
        cyc(1, 16'h0F00, {32'h0, 32'hCCCC_DDDD, 64'h0}, 0);
        // R3: commit with top lane
        cur_req = "R3";
        cyc(1, 16'hF000, CMT | {32'h0123_4567, 96'h0}, 0);
        cyc(0, '0, '0, 0);
        cur_req = "R8";
        cyc(0, '0, '0, 1);
        // R4: flag set but top lane disabled; top lane enabled with flag clear
        cur_req = "R4";
        cyc(1, 16'h7FFF, {1'b1, 127'h55}, 0);
        cyc(1, 16'h8000, {8'h12, 120'h0}, 0);
        cyc(0, '0, '0, 0);
        // R5: reuse staging with top-lane-only commit
        cur_req = "R5";
        cyc(1, 16'h8000, CMT, 0);
        cyc(1, 16'h8000, CMT | {8'h0F, 120'h0}, 0);
        cyc(1, 16'h0001, 128'h9, 0);
        cyc(1, 16'h8000, CMT, 0);
        cyc(1, 16'h8000, CMT, 0);
        // R6: full now; pop while full keeps wait asserted this cycle
        cur_req = "R6";
        cyc(0, '0, '0, 0);
        // R7: write during stall ignored
        cur_req = "R7";
        cyc(1, 16'hFFFF, {1'b1, 127'h7777}, 0);
        cur_req = "R6";
        cyc(1, 16'hFFFF, {1'b1, 127'h6666}, 1);
        cur_req = "R7";
        cyc(1, 16'h8000, CMT, 1);
        cur_req = "R8";
        for (int k = 0; k < 6; k++) cyc(0, '0, '0, 1);
        // R8: random mix
        for (int k = 0; k < 400; k++) begin
            logic [BEW-1:0] be;
            logic [DW-1:0] d;
            be = 16'($urandom);
            d = {$urandom, $urandom, $urandom, $urandom};
            cyc(($urandom % 3) != 0, be, d, ($urandom % 4) == 0);
        end
        cyc(0, '0, '0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule